// File: doc/BRIEF.md
# Bitplane Tile Conversion DMA

The block turns one row of packed pixels into planar tile bytes. The pixels sit in sixteen 8-bit bitmap registers, which are split into two banks of eight. One pulse on `start` converts one row. Each output byte collects one bit position from all eight registers of the active bank. The bytes go out as a valid/ready write stream into a 2 KB internal RAM, each with an 11-bit address.

A 4-bit row counter sets two things: the bank that is read and where in the tile the row lands. A 2-bit colour-depth parameter sets how many planar bytes make up a row (8, 4 or 2) and how the destination base is aligned. When the last byte of a row is accepted, a one-cycle `done` pulse follows and the row counter advances, wrapping from 15 to 0. Software can rewind the counter by writing the control register with bit 7 clear.

The write stream follows standard valid/ready back-pressure. `wr_valid` rises on the cycle after a start is taken. A byte transfers on each rising edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the address and data are held unchanged. The row parameters and the active bank are captured when the start is taken, so inputs that change during a row do not affect it.

Top module: `bpconv_dma`

## Requirements
- R1: The effective depth is `cc_param` with the value 3 treated as 2. A row has 8, 4 or 2 bytes for depth 0, 1 or 2, and exactly that many bytes are offered.
- R2: Row counter bit 0 selects the bank: registers 0..7 when it is 0, registers 8..15 when it is 1. Register i is `bitmap[8i+7:8i]`.
- R3: The row base address is formed in three steps. Take `dst_addr` modulo 2048. Clear its low 7, 6 or 5 bits for depth 0, 1 or 2. Then add (counter bit 3) times the bytes per row, plus (counter bits 2:0) times 2. The result is taken modulo 2048.
- R4: For byte k, data bit (7-i) equals bit k of register i of the active bank, for i = 0..7.
- R5: Bytes are offered in order k = 0, 1, 2, ... Byte k goes to the row base plus 16*(k div 2) plus (k mod 2), modulo 2048.
- R6: The row counter starts at 0 after reset. It increments by one after each completed row and wraps from 15 to 0.
- R7: A control write (`ctrl_we`) with `ctrl_wdata[7]` = 0 resets the row counter to 0. A control write with bit 7 = 1 leaves the counter unchanged.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold. When `wr_ready` stays high, one byte transfers per clock.
- R9: `done` is high for exactly one cycle, the cycle after the last byte transfers. `wr_valid` is low during that cycle.
- R10: A `start` pulse that arrives while a row is in progress is ignored. It neither restarts the row nor queues a new one.
- R11: After reset, `wr_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts one row conversion when idle |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data; bit 7 clear rewinds the row counter |
| cc_param | input | 2 | Colour-depth parameter |
| dst_addr | input | DST_W (24) | Destination base address; only the low 11 bits are used |
| bitmap | input | 128 | Sixteen packed bitmap registers |
| wr_valid | output | 1 | Write byte offered |
| wr_ready | input | 1 | RAM accepts the offered byte |
| wr_addr | output | 11 | RAM byte address |
| wr_data | output | 8 | RAM byte data |
| done | output | 1 | One-cycle pulse after the last byte of a row |

## Verification
The bench checks the address pattern at every depth, including the parameter value 3. A design that fails to clamp 3 would clear too few base bits and would emit the wrong number of bytes. It runs rows on odd and even counter values and across the 15-to-0 wrap. A swapped bank select or an unwrapped counter would then produce wrong data or addresses out of the 16-row tile. The bench also stalls `wr_ready` and fires `start` in the middle of a row: a design that advances on valid alone, or that restarts on a second pulse, emits skipped or extra bytes. Finally, it writes the control register with bit 7 set and then with bit 7 clear, which catches a design that rewinds the counter on any write.

// File: rtl/bpconv_pkg.sv
package bpconv_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned BANK_N   = NUM_REGS / 2;
  localparam int unsigned BANK_W   = BANK_N * REG_W;
  localparam int unsigned LINE_W   = 4;
  localparam int unsigned IDX_W    = $clog2(REG_W);
  localparam int unsigned NB_W     = IDX_W + 1;

  typedef logic [1:0] depth_t;

  function automatic depth_t clamp_depth(input logic [1:0] raw);
    return (raw == 2'd3) ? 2'd2 : raw;
  endfunction
endpackage

// File: rtl/bpconv_addr.sv
module bpconv_addr
  import bpconv_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] base_in,
  input  logic [1:0]        depth_raw,
  input  logic [LINE_W-1:0] line,
  output logic [ADDR_W-1:0] row_base,
  output logic [NB_W-1:0]   row_bytes
);
  depth_t            depth;
  logic [ADDR_W-1:0] align_mask;
  logic [ADDR_W-1:0] tile_off;

  always_comb begin
    depth = clamp_depth(depth_raw);
    unique case (depth)
      2'd0:    begin row_bytes = NB_W'(8); align_mask = ~ADDR_W'(7'h7f); end
      2'd1:    begin row_bytes = NB_W'(4); align_mask = ~ADDR_W'(7'h3f); end
      default: begin row_bytes = NB_W'(2); align_mask = ~ADDR_W'(7'h1f); end
    endcase
    tile_off = (line[3] ? ADDR_W'(row_bytes) : '0) + ADDR_W'({line[2:0], 1'b0});
    row_base = (base_in & align_mask) + tile_off;
  end

  always_comb begin
    p_even_base_r3: assert (row_base[0] == 1'b0);
  end
endmodule

// File: rtl/bpconv_xpose.sv
module bpconv_xpose
  import bpconv_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  input  logic [IDX_W-1:0]  sel,
  output logic [REG_W-1:0]  byte_out
);
  logic [REG_W-1:0] plane [REG_W];

  for (genvar k = 0; k < REG_W; k++) begin : g_plane
    for (genvar i = 0; i < BANK_N; i++) begin : g_bit
      assign plane[k][REG_W-1-i] = bank[i*REG_W + k];
    end
  end

  assign byte_out = plane[sel];
endmodule

// File: rtl/bpconv_ctl.sv
module bpconv_ctl
  import bpconv_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              line_clr,
  input  logic              ready,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [NB_W-1:0]   bytes_in,
  input  logic [BANK_W-1:0] bank_in,
  output logic [LINE_W-1:0] line,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] base_q,
  output logic [BANK_W-1:0] bank_q
);
  logic [NB_W-1:0] bytes_q;
  logic            last;

  assign last = (NB_W'(idx) == bytes_q - NB_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      line    <= '0;
      base_q  <= '0;
      bytes_q <= NB_W'(2);
      bank_q  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy    <= 1'b1;
        idx     <= '0;
        base_q  <= base_in;
        bytes_q <= bytes_in;
        bank_q  <= bank_in;
      end else if (busy && ready) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          line <= line + LINE_W'(1);
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
      if (line_clr) line <= '0;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ready |=> busy && $stable(idx));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base_q) && $stable(bank_q));
  p_line_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !$past(line_clr) |-> line == $past(line) + LINE_W'(1));
  p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(bytes_q) && bytes_q >= NB_W'(2) && NB_W'(idx) < bytes_q);
endmodule

// File: rtl/bpconv_dma.sv
module bpconv_dma
  import bpconv_pkg::*;
#(
  parameter int unsigned DST_W  = 24,
  parameter int unsigned ADDR_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       ctrl_we,
  input  logic [7:0]                 ctrl_wdata,
  input  logic [1:0]                 cc_param,
  input  logic [DST_W-1:0]           dst_addr,
  input  logic [NUM_REGS*REG_W-1:0]  bitmap,
  output logic                       wr_valid,
  input  logic                       wr_ready,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [REG_W-1:0]           wr_data,
  output logic                       done
);
  logic [LINE_W-1:0] line;
  logic [ADDR_W-1:0] row_base, base_q;
  logic [NB_W-1:0]   row_bytes;
  logic [BANK_W-1:0] bank_live, bank_q;
  logic [IDX_W-1:0]  idx;
  logic              busy;
  logic              line_clr;

  assign line_clr  = ctrl_we && !ctrl_wdata[7];
  assign bank_live = line[0] ? bitmap[2*BANK_W-1:BANK_W] : bitmap[BANK_W-1:0];

  bpconv_addr #(.ADDR_W(ADDR_W)) u_addr (
    .base_in   (dst_addr[ADDR_W-1:0]),
    .depth_raw (cc_param),
    .line      (line),
    .row_base  (row_base),
    .row_bytes (row_bytes)
  );

  bpconv_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .line_clr (line_clr),
    .ready    (wr_ready),
    .base_in  (row_base),
    .bytes_in (row_bytes),
    .bank_in  (bank_live),
    .line     (line),
    .busy     (busy),
    .done     (done),
    .idx      (idx),
    .base_q   (base_q),
    .bank_q   (bank_q)
  );

  bpconv_xpose u_xpose (
    .bank     (bank_q),
    .sel      (idx),
    .byte_out (wr_data)
  );

  assign wr_valid = busy;
  assign wr_addr  = base_q + ADDR_W'({idx[2:1], 3'b000, idx[0]});

  p_stream_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_clr |=> line == '0);
endmodule

// File: tb/bpconv_dma_tb.sv
module bpconv_dma_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         ctrl_we = 1'b0;
  logic [7:0]   ctrl_wdata = '0;
  logic [1:0]   cc_param = '0;
  logic [23:0]  dst_addr = '0;
  logic [127:0] bitmap;
  logic         wr_valid;
  logic         wr_ready = 1'b0;
  logic [10:0]  wr_addr;
  logic [7:0]   wr_data;
  logic         done;

  logic [7:0] regs [16];
  int checks = 0;
  int fails  = 0;
  int mline  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  always_comb
    for (int r = 0; r < 16; r++) bitmap[r*8 +: 8] = regs[r];

  bpconv_dma u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .cc_param(cc_param), .dst_addr(dst_addr),
    .bitmap(bitmap), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input int param);
    int d = param & 3;
    if (d > 2) d = 2;
    return 2 << (2 - d);
  endfunction

  function automatic int exp_addr(input int param, input int dst, input int line, input int k);
    int d = param & 3;
    int a;
    if (d > 2) d = 2;
    a = dst & 'h7ff;
    a = a & ~((1 << (7 - d)) - 1);
    a = a + ((line >> 3) & 1) * nbytes(param) + (line & 7) * 2;
    a = a + ((k & 6) << 3) + (k & 1);
    return a & 'h7ff;
  endfunction

  function automatic int exp_data(input int line, input int k);
    int base = (line & 1) ? 8 : 0;
    int v = 0;
    for (int i = 0; i < 8; i++) v |= ((regs[base + i] >> k) & 1) << (7 - i);
    return v;
  endfunction

  task automatic run_row(input int param, input int dst, input bit stall, input bit poke,
                         input string atag, input string dtag);
    int nb = nbytes(param);
    int n = 0;
    int cyc = 0;
    bit held = 0;
    bit rdy;
    logic [10:0] pa;
    logic [7:0]  pd;
    cc_param = 2'(param);
    dst_addr = 24'(dst);
    @(negedge clk);
    start = 1'b1;
    wr_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (n < nb && cyc < 60) begin
      if (held) begin
        chk(wr_valid && wr_addr == pa, "R8", wr_addr, pa);
        chk(wr_data == pd, "R8", wr_data, pd);
      end
      rdy = !stall || (cyc % 3 != 1);
      wr_ready = rdy;
      start = (poke && cyc == 2);
      chk(wr_valid == 1'b1, "R8", wr_valid, 1);
      chk(done == 1'b0, "R9", done, 0);
      if (wr_valid && rdy) begin
        chk(wr_addr == 11'(exp_addr(param, dst, mline, n)), atag, wr_addr, exp_addr(param, dst, mline, n));
        chk(wr_data == 8'(exp_data(mline, n)), dtag, wr_data, exp_data(mline, n));
        n++;
        held = 0;
      end else begin
        held = 1;
        pa = wr_addr;
        pd = wr_data;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    wr_ready = 1'b0;
    chk(n == nb, "R1", n, nb);
    chk(done == 1'b1, "R9", done, 1);
    chk(wr_valid == 1'b0, "R1", wr_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", done, 0);
    chk(wr_valid == 1'b0, poke ? "R10" : "R9", wr_valid, 0);
    mline = (mline + 1) & 15;
  endtask

  task automatic ctrl_write(input logic [7:0] v);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    if (!v[7]) mline = 0;
  endtask

  task automatic fill_regs(input int seed);
    for (int r = 0; r < 16; r++) regs[r] = 8'((seed * 37 + r * 73 + (r * r) * 11) ^ (seed >> 1));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(wr_valid == 1'b0, "R11", wr_valid, 0);
    chk(done == 1'b0, "R11", done, 0);
  endtask

  task automatic t_depth0_even;  // R3 R4 on line 0
    run_row(0, 'h1A3F5, 0, 0, "R3", "R4");
  endtask

  task automatic t_bank_odd;     // R2 upper bank on line 1
    fill_regs(5);
    run_row(0, 'h0123, 0, 0, "R3", "R2");
  endtask

  task automatic t_stall_depth1; // R5 ordering with R8 back-pressure
    run_row(1, 'h7FF, 1, 0, "R5", "R4");
  endtask

  task automatic t_clamp_poke;   // R1 clamp of 3, R10 start mid-row
    fill_regs(9);
    run_row(3, 'h2C7, 1, 1, "R1", "R4");
    run_row(2, 'h555, 0, 1, "R3", "R2");
  endtask

  task automatic t_ctrl;         // R7
    ctrl_write(8'h80);
    run_row(1, 'h3AB, 0, 0, "R7", "R2");
    ctrl_write(8'h00);
    run_row(1, 'h3AB, 0, 0, "R7", "R4");
  endtask

  task automatic t_wrap;         // R6 across 15 -> 0
    for (int r = 0; r < 17; r++) begin
      fill_regs(r + 20);
      run_row(r % 3, 'h6E0 + r * 3, 0, 0, "R6", "R4");
    end
  endtask

  initial begin
    fill_regs(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_depth0_even();
    t_bank_odd();
    t_stall_depth1();
    t_clamp_poke();
    t_ctrl();
    t_wrap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule